// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block watches one asynchronous interrupt pin and raises a pending flag when the pin makes a transition of the chosen polarity. It also holds the global interrupt-enable state, which the processor core moves only through single-cycle instruction strobes (enable, disable, return from interrupt) and through its acknowledge of a taken interrupt. The interrupt request presented to the core is the pending flag gated by that enable.

Software sees a small control register. One bit selects the active edge and another reports the enable state. The enable bit is read-only in that register: a register write never moves it. The pending flag records qualifying edges even while interrupts are disabled, and only an explicit clear strobe removes it.

Top module: `eic_top`

## Requirements
- R1: After reset the enable bit, the pending flag, the edge select, the request and the whole read value of the control register are 0.
- R2: With the edge select at 0, a low-to-high transition of the pin sets the pending flag and a high-to-low transition does not.
- R3: With the edge select at 1, a high-to-low transition of the pin sets the pending flag and a low-to-high transition does not.
- R4: The pending flag sets whether or not interrupts are enabled and stays set until the clear strobe. The acknowledge does not clear it. When a qualifying edge and the clear strobe land in the same cycle, the flag ends up set.
- R5: The request output equals the pending flag ANDed with the enable bit, in every cycle.
- R6: The enable strobe or the return strobe sets the enable bit on the next clock edge.
- R7: The disable strobe or the acknowledge clears the enable bit on the next clock edge. A clearing strobe wins over a setting strobe in the same cycle.
- R8: A control-register write loads the edge select from write bit 7 and ignores write bit 6. The read value carries the edge select at bit 7, the enable bit at bit 6 and 0 in all other bits.
- R9: A pin transition sets the pending flag on the third rising clock edge after the pin changes. Changing the edge select while the pin is steady does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pin | input | 1 | Asynchronous external interrupt pin |
| cfg_we | input | 1 | Control-register write strobe |
| cfg_wdata | input | 8 | Control-register write data |
| cfg_rdata | output | 8 | Control-register read value |
| ie_on_stb | input | 1 | Enable-interrupts strobe |
| ie_off_stb | input | 1 | Disable-interrupts strobe |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| irq_ack | input | 1 | Core has taken the interrupt |
| pend_clr | input | 1 | Clear the pending flag |
| pend | output | 1 | Pending interrupt flag |
| irq_req | output | 1 | Interrupt request to the core |
| ie | output | 1 | Global interrupt enable (read only) |

## Verification
A pin change passes two synchronizer flops and the edge-compare flop, so the pending flag is due three rising edges after the pin moves. The bench checks it still clear after two edges and set after the third. Strobes and register writes show on the enable bit and the read value one edge later, and the request is combinational from those registers. The bench drives every input at the falling clock edge and samples at the next falling edge after counting exactly the rising edges that lie in the path.

// File: rtl/eic_pkg.sv
package eic_pkg;
    typedef struct packed {
        logic pend;
        logic edge_sel;
    } eic_state_t;

    typedef struct packed {
        logic prev;
    } edge_state_t;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_async;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_async};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_sync = chain_q[LAST];
endmodule

// File: rtl/eic_edge.sv
module eic_edge
    import eic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_in,
    input  logic falling,
    output logic hit
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = s_in;
        if (falling) hit = st_q.prev & ~s_in;
        else         hit = ~st_q.prev & s_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a low-to-high step of the synchronized pin is reported when rising is selected
    a_r2_rise_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!falling && s_in && !$past(s_in)) |-> hit);
    // R3: a high-to-low step is reported when falling is selected
    a_r3_fall_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (falling && !s_in && $past(s_in)) |-> hit);
    // R9: a steady synchronized pin never yields a hit
    a_r9_steady_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_in == $past(s_in)) |-> !hit);
endmodule

// File: rtl/eic_gie.sv
module eic_gie (
    input  logic clk,
    input  logic rst_n,
    input  logic on_stb,
    input  logic off_stb,
    input  logic ret_stb,
    input  logic ack,
    output logic gie
);
    logic gie_d, gie_q;
    logic set_req, clr_req;

    always_comb begin
        set_req = on_stb | ret_stb;
        clr_req = off_stb | ack;
        gie_d   = gie_q;
        if (clr_req)      gie_d = 1'b0;
        else if (set_req) gie_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gie_q <= 1'b0;
        else        gie_q <= gie_d;
    end

    assign gie = gie_q;

    // R7: disable or acknowledge drops the enable on the next edge
    a_r7_off_next: assert property (@(posedge clk) disable iff (!rst_n)
        (off_stb || ack) |=> !gie_q);
    // R6: the enable rises only after an enable or return strobe
    a_r6_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie_q) |-> $past(on_stb || ret_stb));
    // R7: the enable falls only after disable or acknowledge
    a_r7_fall_src: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gie_q) |-> $past(off_stb || ack));
endmodule

// File: rtl/eic_top.sv
module eic_top
    import eic_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SEL_BIT     = 7,
    parameter int IE_BIT      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_pin,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          ie_on_stb,
    input  logic          ie_off_stb,
    input  logic          ret_stb,
    input  logic          irq_ack,
    input  logic          pend_clr,
    output logic          pend,
    output logic          irq_req,
    output logic          ie
);
    eic_state_t st_d, st_q;
    logic pin_s, hit, gie;

    eic_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(irq_pin), .q_sync(pin_s)
    );

    eic_edge u_edge (
        .clk(clk), .rst_n(rst_n), .s_in(pin_s), .falling(st_q.edge_sel), .hit(hit)
    );

    eic_gie u_gie (
        .clk(clk), .rst_n(rst_n), .on_stb(ie_on_stb), .off_stb(ie_off_stb),
        .ret_stb(ret_stb), .ack(irq_ack), .gie(gie)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = hit | (st_q.pend & ~pend_clr);
        if (cfg_we) st_d.edge_sel = cfg_wdata[SEL_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata          = '0;
        cfg_rdata[SEL_BIT] = st_q.edge_sel;
        cfg_rdata[IE_BIT]  = gie;
    end

    assign pend    = st_q.pend;
    assign ie      = gie;
    assign irq_req = st_q.pend & gie;

    // R4: a qualifying edge always leaves the flag set, even with a clear
    a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend);
    // R4: the flag falls only after a clear strobe
    a_r4_fall_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(pend_clr));
    // R8: a register write without any strobe leaves the enable alone
    a_r8_ie_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !ie_on_stb && !ie_off_stb && !ret_stb && !irq_ack) |=> (ie == $past(ie)));
    // R5: no request without both a pending flag and the enable
    a_r5_req_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend && cfg_rdata[IE_BIT]));
endmodule

// File: tb/sim_eic_top.sv
module sim_eic_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       ie_on_stb = 1'b0, ie_off_stb = 1'b0, ret_stb = 1'b0;
    logic       irq_ack = 1'b0, pend_clr = 1'b0;
    logic       pend, irq_req, ie;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    eic_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ie_on_stb(ie_on_stb),
        .ie_off_stb(ie_off_stb), .ret_stb(ret_stb), .irq_ack(irq_ack),
        .pend_clr(pend_clr), .pend(pend), .irq_req(irq_req), .ie(ie)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ie(input bit v);
        if (v) ie_on_stb = 1'b1; else ie_off_stb = 1'b1;
        tick();
        ie_on_stb = 1'b0; ie_off_stb = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clr_pend();
        pend_clr = 1'b1;
        tick();
        pend_clr = 1'b0;
    endtask

    initial begin
        tick(3);
        chk("R1 ie", ie, 0);
        chk("R1 pend", pend, 0);
        chk("R1 req", irq_req, 0);
        chk("R1 rdata", cfg_rdata, 8'h00);
        rst_n = 1'b1;
        tick();
        chk("R1 rdata after release", cfg_rdata, 8'h00);

        // Edge polarity sweep: select x enable state
        for (int sel = 0; sel < 2; sel++) begin
            set_ie(1'b0);
            wr_cfg(sel ? 8'hC0 : 8'h40);
            chk("R8 write ignores bit 6", cfg_rdata, sel ? 8'h80 : 8'h00);
            irq_pin = sel[0];
            tick(4);
            clr_pend();
            chk("R2/R3 idle clear", pend, 0);
            for (int g = 0; g < 2; g++) begin
                set_ie(g[0]);
                irq_pin = ~irq_pin;           // qualifying transition
                tick(2);
                chk("R9 not yet after two edges", pend, 0);
                tick();
                chk(sel ? "R3 falling sets" : "R2 rising sets", pend, 1);
                chk("R4 set regardless of enable", pend, 1);
                chk("R5 req", irq_req, g[0]);
                irq_ack = 1'b1;
                tick();
                irq_ack = 1'b0;
                chk("R4 ack keeps pend", pend, 1);
                chk("R7 ack clears ie", ie, 0);
                tick(5);
                chk("R4 holds without clear", pend, 1);
                clr_pend();
                chk("R4 clear strobe", pend, 0);
                irq_pin = ~irq_pin;           // opposite transition
                tick(4);
                chk(sel ? "R3 rising ignored" : "R2 falling ignored", pend, 0);
            end
        end

        // Strobe sweep: R6 / R7
        for (int init = 0; init < 2; init++) begin
            for (int c = 0; c < 16; c++) begin
                logic on_b, off_b, ret_b, ack_b, exp_ie;
                set_ie(init[0]);
                on_b = c[0]; off_b = c[1]; ret_b = c[2]; ack_b = c[3];
                ie_on_stb = on_b; ie_off_stb = off_b; ret_stb = ret_b; irq_ack = ack_b;
                tick();
                ie_on_stb = 0; ie_off_stb = 0; ret_stb = 0; irq_ack = 0;
                exp_ie = (off_b | ack_b) ? 1'b0 : ((on_b | ret_b) ? 1'b1 : init[0]);
                chk((off_b | ack_b) ? "R7 strobe sweep" : "R6 strobe sweep", ie, exp_ie);
                chk("R8 read bit 6", cfg_rdata[6], exp_ie);
            end
        end

        // R8: writes do not move enable
        set_ie(1'b1);
        wr_cfg(8'h00);
        chk("R8 write 0 keeps ie", ie, 1);
        set_ie(1'b0);
        wr_cfg(8'hFF);
        chk("R8 write FF keeps ie", ie, 0);
        chk("R8 read value", cfg_rdata, 8'h80);

        // R9: select change with steady pin
        wr_cfg(8'h00);
        irq_pin = 1'b1;
        tick(4);
        clr_pend();
        wr_cfg(8'h80);
        tick(4);
        chk("R9 select change quiet", pend, 0);
        wr_cfg(8'h00);
        tick(4);
        chk("R9 select change back quiet", pend, 0);

        // R4: clear in the same cycle as a qualifying edge
        irq_pin = 1'b0;
        tick(4);
        clr_pend();
        irq_pin = 1'b1;
        tick(2);
        pend_clr = 1'b1;
        tick();
        pend_clr = 1'b0;
        chk("R4 edge beats clear", pend, 1);
        set_ie(1'b1);
        chk("R5 req high", irq_req, 1);
        clr_pend();
        chk("R5 req low after clear", irq_req, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule